// File: doc/BRIEF.md
# Instruction Breakpoint and Trace Detector

This block sits next to the completion stage of an in-order core. It tells the exception controller when an instruction-address breakpoint or a trace exception is due. A breakpoint register can be written by software. It holds a word address and an enable flag. The block compares that register against the address of the instruction that is next to complete.

The block also looks at the instruction that completes in each cycle. It raises a trace request on every completion while single-step is enabled. While branch-trace is enabled, it raises a trace request only when the completing instruction is a branch. The exception controller uses each request line together with the vector offset that comes with it.

A breakpoint is reported before its instruction completes. For that reason it takes precedence over any trace request decided in the same cycle. When the exception controller signals an exception entry, the block drops all requests for that cycle and the following one. The controller clears the trace enables during that window.

Top module: `ibrk_trace_detect`

## Requirements
- R1: After reset both request lines and both vector outputs are 0, and the breakpoint is disabled, so no address produces a breakpoint request.
- R2: A write (`bp_wr_en`=1) loads the word address from `bp_wr_data[31:2]` and the enable flag from `bp_wr_data[1]`. `bp_wr_data[0]` is ignored.
- R3: When the breakpoint is enabled and `next_valid`=1 with `next_addr[31:2]` equal to the stored address, `bp_req` is 1 in the cycle after that input.
- R4: Bits `next_addr[1:0]` take no part in the comparison.
- R5: With the enable flag cleared, no breakpoint request is raised even on an address match.
- R6: When `cmpl_valid`=1 and `msr_se`=1, `trace_req` is 1 in the next cycle, whatever the instruction type.
- R7: When `msr_se`=0 and `msr_be`=1, a trace request follows a completion only when `cmpl_is_branch`=1.
- R8: If a breakpoint hit and a trace condition occur in the same cycle, only `bp_req` is raised.
- R9: Any stimulus presented in a cycle with `exc_entry`=1, or in the cycle right after it, raises no request.
- R10: `bp_vec` is 0x01300 while `bp_req`=1 and 0 otherwise. `trace_vec` is 0x00D00 while `trace_req`=1 and 0 otherwise.
- R11: A compare made in the same cycle as a register write uses the old register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bp_wr_en | input | 1 | Breakpoint register write strobe |
| bp_wr_data | input | 32 | Write data: [31:2] address, [1] enable |
| next_valid | input | 1 | An instruction is next to complete |
| next_addr | input | 32 | Address of the next instruction to complete |
| cmpl_valid | input | 1 | An instruction completes this cycle |
| cmpl_is_branch | input | 1 | The completing instruction is a branch |
| msr_se | input | 1 | Single-step trace enable |
| msr_be | input | 1 | Branch trace enable |
| exc_entry | input | 1 | Exception entry pulse from the controller |
| bp_req | output | 1 | Breakpoint exception request |
| bp_vec | output | 20 | Breakpoint vector offset |
| trace_req | output | 1 | Trace exception request |
| trace_vec | output | 20 | Trace vector offset |

## Verification
A breakpoint hit and a trace condition can fall in the same cycle. The bench provokes this by presenting a matching next address while a completion happens with single-step on. It then expects only the breakpoint line and its vector, with the trace line low. The same overlap is also driven during an exception entry and the cycle after it, where both lines must stay low. Once that window has passed, the breakpoint must win again.

// File: rtl/ibrk_trace_detect.sv
module ibrk_trace_detect #(
  parameter int          AW     = 32,
  parameter int          VW     = 20,
  parameter logic [19:0] BP_VEC = 20'h01300,
  parameter logic [19:0] TR_VEC = 20'h00D00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bp_wr_en,
  input  logic [AW-1:0] bp_wr_data,
  input  logic          next_valid,
  input  logic [AW-1:0] next_addr,
  input  logic          cmpl_valid,
  input  logic          cmpl_is_branch,
  input  logic          msr_se,
  input  logic          msr_be,
  input  logic          exc_entry,
  output logic          bp_req,
  output logic [VW-1:0] bp_vec,
  output logic          trace_req,
  output logic [VW-1:0] trace_vec
);
  localparam int FW = AW - 2;

  logic [FW-1:0] bp_addr_q;
  logic          bp_en_q;
  logic          blk_q;

  wire unused_bits = ^{bp_wr_data[0], next_addr[1:0]};

  wire hit   = bp_en_q & next_valid & (next_addr[AW-1:2] == bp_addr_q);
  wire trc   = cmpl_valid & (msr_se | (msr_be & cmpl_is_branch));
  wire quiet = exc_entry | blk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bp_addr_q <= '0;
      bp_en_q   <= 1'b0;
      blk_q     <= 1'b0;
      bp_req    <= 1'b0;
      trace_req <= 1'b0;
    end else begin
      if (bp_wr_en) begin
        bp_addr_q <= bp_wr_data[AW-1:2];
        bp_en_q   <= bp_wr_data[1];
      end
      blk_q     <= exc_entry;
      bp_req    <= hit & ~quiet;
      trace_req <= trc & ~hit & ~quiet;
    end
  end

  assign bp_vec    = bp_req    ? VW'(BP_VEC) : '0;
  assign trace_vec = trace_req ? VW'(TR_VEC) : '0;
endmodule

// File: rtl/ibrk_trace_detect_chk.sv
module ibrk_trace_detect_chk #(
  parameter int AW = 32,
  parameter int VW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          next_valid,
  input logic          cmpl_valid,
  input logic          exc_entry,
  input logic          bp_req,
  input logic [VW-1:0] bp_vec,
  input logic          trace_req,
  input logic [VW-1:0] trace_vec
);
  assert_one_winner_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bp_req && trace_req));
  assert_bp_vec_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bp_req |-> bp_vec == VW'(20'h01300));
  assert_tr_vec_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trace_req |-> trace_vec == VW'(20'h00D00));
  assert_entry_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    exc_entry |=> !bp_req && !trace_req);
  assert_bp_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bp_req |-> $past(next_valid));
  assert_tr_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trace_req |-> $past(cmpl_valid));
endmodule

bind ibrk_trace_detect ibrk_trace_detect_chk #(.AW(AW), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .next_valid(next_valid), .cmpl_valid(cmpl_valid),
  .exc_entry(exc_entry), .bp_req(bp_req), .bp_vec(bp_vec),
  .trace_req(trace_req), .trace_vec(trace_vec));

// File: tb/ibrk_trace_detect_test.sv
module ibrk_trace_detect_test;
  logic clk = 0, rst_n = 0;
  logic bp_wr_en = 0, next_valid = 0, cmpl_valid = 0, cmpl_is_branch = 0;
  logic msr_se = 0, msr_be = 0, exc_entry = 0;
  logic [31:0] bp_wr_data = 0, next_addr = 0;
  logic bp_req, trace_req;
  logic [19:0] bp_vec, trace_vec;

  ibrk_trace_detect uut (.*);

  always #5 clk = ~clk;

  typedef struct { logic bp; logic tr; string tag; } exp_t;
  exp_t q[$];
  int tests = 0, fails = 0;
  logic [29:0] m_addr = 0;
  logic m_en = 0, m_blk = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic wr, logic [31:0] wd, logic nv, logic [31:0] na,
                      logic cv, logic br, logic se, logic be, logic ex, string tag);
    exp_t e;
    logic h;
    @(negedge clk);
    bp_wr_en = wr; bp_wr_data = wd; next_valid = nv; next_addr = na;
    cmpl_valid = cv; cmpl_is_branch = br; msr_se = se; msr_be = be; exc_entry = ex;
    h = m_en && nv && (na[31:2] == m_addr);
    e.bp = h && !ex && !m_blk;
    e.tr = cv && (se || (be && br)) && !h && !ex && !m_blk;
    e.tag = tag;
    q.push_back(e);
    m_blk = ex;
    if (wr) begin m_addr = wd[31:2]; m_en = wd[1]; end
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk); #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        chk({e.tag, " bp_req"}, {31'b0, bp_req}, {31'b0, e.bp});
        chk({e.tag, " trace_req"}, {31'b0, trace_req}, {31'b0, e.tr});
        chk("R10 bp_vec", {12'b0, bp_vec}, e.bp ? 32'h01300 : 32'h0);
        chk("R10 trace_vec", {12'b0, trace_vec}, e.tr ? 32'h00D00 : 32'h0);
      end
    end
  end

  initial begin : watchdog
    #200000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 reset bp_req", {31'b0, bp_req}, 0);
    chk("R1 reset trace_req", {31'b0, trace_req}, 0);
    chk("R1 reset vecs", {bp_vec[15:0], trace_vec[15:0]}, 0);
    step(0, 0, 1, 32'h0, 0, 0, 0, 0, 0, "R1 disabled after reset");
    step(1, 32'h1000_0042, 1, 32'h1000_0040, 0, 0, 0, 0, 0, "R11 old value");
    step(0, 0, 1, 32'h1000_0040, 0, 0, 0, 0, 0, "R3 match");
    step(0, 0, 1, 32'h1000_0043, 0, 0, 0, 0, 0, "R4 low bits");
    step(0, 0, 1, 32'h1000_0044, 0, 0, 0, 0, 0, "R3 mismatch");
    step(0, 0, 0, 32'h1000_0040, 0, 0, 0, 0, 0, "R3 not valid");
    step(1, 32'h1000_0041, 0, 0, 0, 0, 0, 0, 0, "R2 write disabled");
    step(0, 0, 1, 32'h1000_0040, 0, 0, 0, 0, 0, "R5 disabled");
    step(1, 32'h2000_0102, 0, 0, 0, 0, 0, 0, 0, "R2 write enabled");
    step(0, 0, 1, 32'h2000_0100, 0, 0, 0, 0, 0, "R2 new address");
    step(0, 0, 1, 32'h1000_0040, 0, 0, 0, 0, 0, "R2 old address gone");
    step(0, 0, 0, 0, 1, 0, 1, 0, 0, "R6 single-step");
    step(0, 0, 0, 0, 1, 1, 1, 0, 0, "R6 single-step branch");
    step(0, 0, 0, 0, 1, 0, 0, 1, 0, "R7 non-branch");
    step(0, 0, 0, 0, 1, 1, 0, 1, 0, "R7 branch");
    step(0, 0, 0, 0, 0, 1, 1, 1, 0, "R6 no completion");
    step(0, 0, 1, 32'h2000_0100, 1, 0, 1, 0, 0, "R8 overlap");
    step(0, 0, 1, 32'h2000_0100, 1, 1, 0, 1, 0, "R8 overlap branch");
    step(0, 0, 1, 32'h2000_0100, 1, 0, 1, 0, 1, "R9 entry cycle");
    step(0, 0, 1, 32'h2000_0100, 1, 0, 1, 0, 0, "R9 after entry");
    step(0, 0, 1, 32'h2000_0100, 1, 0, 1, 0, 0, "R8 after window");
    step(0, 0, 0, 0, 1, 0, 1, 0, 1, "R9 entry trace");
    step(0, 0, 0, 0, 1, 1, 0, 1, 0, "R9 after entry trace");
    step(0, 0, 0, 0, 1, 1, 0, 1, 0, "R7 after window");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R1 idle");
    @(negedge clk); @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule